// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

The expander gathers 96 single-cycle interrupt request pulses from peripherals and folds them onto 12 CPU interrupt lines. The requests are arranged as 12 groups of 8 sources. Every source has a latched flag and an enable bit. Every group has an acknowledge gate that stops the group raising its line again until software reopens it. Software reaches the control register, the acknowledge register and the per-group enable and flag registers through a 16-bit, word-addressed register bus. Writes take effect at the clock edge, and reads are combinational.

When the CPU takes a group interrupt, it presents the group number on the acknowledge port. The expander then picks the lowest-numbered pending source in that group, clears its flag and closes the group's gate. One cycle later it returns that source's vector-table address for a single cycle. A software trap request names a group and receives the address of that group's first source. A trap naming group 0 receives an error pulse instead, because the table has no reset entry.

Top module: `irq_group_expander`

## Requirements
- R1: Group line g is high exactly when the global enable is set, the group's acknowledge bit is clear, and at least one source of the group has both its flag and its enable bit set. A flag whose enable bit is clear raises no line.
- R2: A request pulse on input bit 8·(g-1)+(i-1) sets the flag of source i of group g at the next edge. The flag stays set until it is serviced or overwritten by software.
- R3: Within a group, the lowest source index that is flagged and enabled wins. The returned address is 0xD40 + 0x10·(g-1) + 2·(i-1).
- R4: An acknowledge for a group whose line is high clears only the winning flag and sets the group's acknowledge bit. The vector address appears one cycle later, with the valid output high for that one cycle.
- R5: Writing 1 to bit g-1 of the acknowledge register (offset 1) clears that group's acknowledge bit. Writing 0 to a bit leaves it unchanged. A read of offset 1 returns the acknowledge bits in bits 11:0.
- R6: While enabled, a trap numbered 1 to 12 returns the address of source 1 of that group one cycle later, whatever the flag, enable and acknowledge state, and it changes none of these.
- R7: While enabled, a trap numbered 0 (or above 12) pulses the error output one cycle later and does not assert the valid output.
- R8: Bit 0 of the control register (offset 0) is the global enable. While it is clear, all lines are low, and traps and acknowledges produce neither a vector nor an error.
- R9: The enable register of group g is at offset 2+2(g-1) and its flag register at offset 3+2(g-1), each holding its 8 bits in bits 7:0. Offsets 0x1A to 0x1F read as zero.
- R10: A software write to a flag register loads the written bits. A request pulse arriving in the same cycle still leaves its flag set.
- R11: Setting a flag by software on an enabled source raises the group line like a hardware request, so it can be used as a software interrupt.
- R12: After reset, all registers, lines, the valid output and the error output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 96 | Request pulses, bit 8·(g-1)+(i-1) for source i of group g |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the offset |
| cpu_irq_o | output | 12 | CPU interrupt line per group, bit g-1 for group g |
| cpu_ack_i | input | 1 | CPU acknowledge strobe |
| cpu_ack_grp_i | input | 4 | Group number 1..12 being acknowledged |
| trap_i | input | 1 | Software trap request strobe |
| trap_num_i | input | 4 | Trap number |
| vec_valid_o | output | 1 | Vector address valid for one cycle |
| vec_addr_o | output | 12 | Vector-table address, zero when not valid |
| trap_err_o | output | 1 | Pulse on a trap with no valid vector |

## Verification
Arbitration is exercised with two sources of one group raised together. Servicing that group twice must return the lower address first and then the higher one, which separates a priority error from a flag-clearing error. Traps are issued for the first and the last group while unrelated flags are pending, showing that the trap path ignores flag state. Trap numbers 0 and 13 check the error path. A flag-register clear is written in the same cycle as a fresh request to show that hardware requests are never lost. Masked flags, a software-set flag and the disabled state separate the line-gating terms from one another.

// File: rtl/irqx_pkg.sv
// Shared constants and the vector-address computation for the expander.
// Assumes vector addresses fit in VEC_W bits.
package irqx_pkg;
    localparam int VEC_W       = 12;
    localparam int VEC_BASE    = 32'hD40;
    localparam int GRP_STRIDE  = 32'h10;
    localparam int SLOT_STRIDE = 2;

    // Vector address for zero-based group g0 and zero-based source s0.
    function automatic logic [VEC_W-1:0] vec_of(input int g0, input int s0);
        int full;
        full = VEC_BASE + g0 * GRP_STRIDE + s0 * SLOT_STRIDE;
        return full[VEC_W-1:0];
    endfunction
endpackage

// File: rtl/irqx_group.sv
// One interrupt group: flags, per-source enables and the acknowledge gate.
// Assumes the request pulses are synchronous to clk. The service strobe is
// raised only when this group's line is high.
module irqx_group #(
    parameter int GRP_W  = 8,
    localparam int SIDX_W = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_W-1:0]  req_i,
    input  logic              glb_en_i,
    input  logic              ier_we_i,
    input  logic              ifr_we_i,
    input  logic [GRP_W-1:0]  wdata_i,
    input  logic              ack_clr_i,
    input  logic              svc_i,
    output logic [GRP_W-1:0]  flags_o,
    output logic [GRP_W-1:0]  ier_o,
    output logic              ack_o,
    output logic              line_o,
    output logic [SIDX_W-1:0] win_o
);
    logic [GRP_W-1:0] pend;
    logic [GRP_W-1:0] clr_mask;

    // Pick the lowest pending and enabled source index.
    always_comb begin
        pend  = flags_o & ier_o;
        win_o = '0;
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (pend[i]) win_o = SIDX_W'(i);
        end
        clr_mask = svc_i ? (GRP_W'(1) << win_o) : '0;
    end

    // Line output: any enabled pending source while the gate is open.
    assign line_o = glb_en_i && !ack_o && (|pend);

    // Flag register: software load or service clear, with requests always ORed in.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_o <= '0;
        else if (ifr_we_i) flags_o <= wdata_i | req_i;
        else               flags_o <= (flags_o & ~clr_mask) | req_i;
    end

    // Enable register: plain software read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ier_o <= '0;
        else if (ier_we_i) ier_o <= wdata_i;
    end

    // Acknowledge gate: closed by service, reopened by a write-1 from software.
    always_ff @(posedge clk) begin
        if (!rst_n)         ack_o <= 1'b0;
        else if (svc_i)     ack_o <= 1'b1;
        else if (ack_clr_i) ack_o <= 1'b0;
    end
endmodule

// File: rtl/irqx_regs.sv
// Register-bus decode: global enable, write strobes for each group and the
// combinational read mux. Offsets beyond the last flag register read zero.
module irqx_regs #(
    parameter int NUM_GRP = 12,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [NUM_GRP*GRP_W-1:0] ier_all_i,
    input  logic [NUM_GRP*GRP_W-1:0] ifr_all_i,
    input  logic [NUM_GRP-1:0]       ack_all_i,
    output logic                     glb_en_o,
    output logic [NUM_GRP-1:0]       ier_we_o,
    output logic [NUM_GRP-1:0]       ifr_we_o,
    output logic [NUM_GRP-1:0]       ack_clr_o,
    output logic [DATA_W-1:0]        rdata_o
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_ACK  = ADDR_W'(1);

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:GRP_W];

    // Global enable bit held in the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           glb_en_o <= 1'b0;
        else if (we_i && addr_i == OFS_CTRL)  glb_en_o <= wdata_i[0];
    end

    // Per-group write strobes decoded from the offset.
    for (genvar k = 0; k < NUM_GRP; k++) begin : g_dec
        assign ier_we_o[k]  = we_i && (addr_i == ADDR_W'(2 + 2 * k));
        assign ifr_we_o[k]  = we_i && (addr_i == ADDR_W'(3 + 2 * k));
        assign ack_clr_o[k] = we_i && (addr_i == OFS_ACK) && wdata_i[k];
    end

    // Read mux with zero for every unmapped offset.
    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_CTRL) begin
            rdata_o[0] = glb_en_o;
        end else if (addr_i == OFS_ACK) begin
            rdata_o[NUM_GRP-1:0] = ack_all_i;
        end else begin
            for (int k = 0; k < NUM_GRP; k++) begin
                if (addr_i == ADDR_W'(2 + 2 * k))
                    rdata_o[GRP_W-1:0] = ier_all_i[k*GRP_W +: GRP_W];
                else if (addr_i == ADDR_W'(3 + 2 * k))
                    rdata_o[GRP_W-1:0] = ifr_all_i[k*GRP_W +: GRP_W];
            end
        end
    end
endmodule

// File: rtl/irqx_dispatch.sv
// Resolves CPU acknowledges and software traps into a one-cycle vector or
// error pulse. A trap takes precedence over an acknowledge in the same cycle.
// Assumes an acknowledge names a group whose line is high; otherwise it is dropped.
module irqx_dispatch #(
    parameter int NUM_GRP = 12,
    parameter int SIDX_W  = 3,
    parameter int GNUM_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        glb_en_i,
    input  logic                        trap_i,
    input  logic [GNUM_W-1:0]           trap_num_i,
    input  logic                        ack_i,
    input  logic [GNUM_W-1:0]           ack_grp_i,
    input  logic [NUM_GRP-1:0]          line_i,
    input  logic [NUM_GRP*SIDX_W-1:0]   win_all_i,
    output logic [NUM_GRP-1:0]          svc_o,
    output logic                        vec_valid_o,
    output logic [irqx_pkg::VEC_W-1:0]  vec_addr_o,
    output logic                        trap_err_o
);
    logic                       trap_ok, trap_bad, ack_ok;
    logic [irqx_pkg::VEC_W-1:0] trap_addr, ack_addr;

    // Decode trap and acknowledge requests and compute their vectors.
    always_comb begin
        trap_ok   = glb_en_i && trap_i && (trap_num_i != '0)
                    && (trap_num_i <= GNUM_W'(NUM_GRP));
        trap_bad  = glb_en_i && trap_i && !trap_ok;
        trap_addr = '0;
        for (int k = 0; k < NUM_GRP; k++) begin
            if (trap_num_i == GNUM_W'(k + 1)) trap_addr = irqx_pkg::vec_of(k, 0);
        end
        svc_o    = '0;
        ack_ok   = 1'b0;
        ack_addr = '0;
        for (int k = 0; k < NUM_GRP; k++) begin
            if (glb_en_i && ack_i && !trap_i && ack_grp_i == GNUM_W'(k + 1) && line_i[k]) begin
                svc_o[k] = 1'b1;
                ack_ok   = 1'b1;
                ack_addr = irqx_pkg::vec_of(k, int'(win_all_i[k*SIDX_W +: SIDX_W]));
            end
        end
    end

    // Register the result so it appears for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_o <= 1'b0;
            vec_addr_o  <= '0;
            trap_err_o  <= 1'b0;
        end else begin
            vec_valid_o <= trap_ok || ack_ok;
            vec_addr_o  <= trap_ok ? trap_addr : (ack_ok ? ack_addr : '0);
            trap_err_o  <= trap_bad;
        end
    end
endmodule

// File: rtl/irq_group_expander.sv
// Top level: 12 groups of 8 request flags folded onto 12 CPU lines, with
// register access, acknowledge gating and trap vectoring.
// Assumes every input is synchronous to clk.
module irq_group_expander #(
    parameter int NUM_GRP = 12,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    localparam int NREQ   = NUM_GRP * GRP_W,
    localparam int SIDX_W = (GRP_W > 1) ? $clog2(GRP_W) : 1,
    localparam int GNUM_W = $clog2(NUM_GRP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NREQ-1:0]            req_i,
    input  logic                       reg_we_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    output logic [NUM_GRP-1:0]         cpu_irq_o,
    input  logic                       cpu_ack_i,
    input  logic [GNUM_W-1:0]          cpu_ack_grp_i,
    input  logic                       trap_i,
    input  logic [GNUM_W-1:0]          trap_num_i,
    output logic                       vec_valid_o,
    output logic [irqx_pkg::VEC_W-1:0] vec_addr_o,
    output logic                       trap_err_o
);
    logic                       glb_en;
    logic [NUM_GRP-1:0]         ier_we, ifr_we, ack_clr, svc, ack_all;
    logic [NREQ-1:0]            ier_all, ifr_all;
    logic [NUM_GRP*SIDX_W-1:0]  win_all;

    irqx_regs #(
        .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .ier_all_i(ier_all), .ifr_all_i(ifr_all),
        .ack_all_i(ack_all), .glb_en_o(glb_en), .ier_we_o(ier_we),
        .ifr_we_o(ifr_we), .ack_clr_o(ack_clr), .rdata_o(reg_rdata_o)
    );

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        irqx_group #(.GRP_W(GRP_W)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .req_i(req_i[k*GRP_W +: GRP_W]),
            .glb_en_i(glb_en),
            .ier_we_i(ier_we[k]), .ifr_we_i(ifr_we[k]),
            .wdata_i(reg_wdata_i[GRP_W-1:0]),
            .ack_clr_i(ack_clr[k]), .svc_i(svc[k]),
            .flags_o(ifr_all[k*GRP_W +: GRP_W]),
            .ier_o(ier_all[k*GRP_W +: GRP_W]),
            .ack_o(ack_all[k]), .line_o(cpu_irq_o[k]),
            .win_o(win_all[k*SIDX_W +: SIDX_W])
        );
    end

    irqx_dispatch #(
        .NUM_GRP(NUM_GRP), .SIDX_W(SIDX_W), .GNUM_W(GNUM_W)
    ) u_disp (
        .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en),
        .trap_i(trap_i), .trap_num_i(trap_num_i),
        .ack_i(cpu_ack_i), .ack_grp_i(cpu_ack_grp_i),
        .line_i(cpu_irq_o), .win_all_i(win_all), .svc_o(svc),
        .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
        .trap_err_o(trap_err_o)
    );
endmodule

// File: rtl/irqx_checker.sv
// Property checker for the expander, attached to the top through bind.
module irqx_checker #(
    parameter int NUM_GRP = 12,
    parameter int GRP_W   = 8,
    parameter int GNUM_W  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       glb_en,
    input logic [NUM_GRP*GRP_W-1:0]   req,
    input logic [NUM_GRP*GRP_W-1:0]   flags,
    input logic [NUM_GRP-1:0]         ack_bits,
    input logic [NUM_GRP-1:0]         cpu_irq,
    input logic                       cpu_ack,
    input logic [GNUM_W-1:0]          cpu_ack_grp,
    input logic                       trap,
    input logic [GNUM_W-1:0]          trap_num,
    input logic                       vec_valid,
    input logic [irqx_pkg::VEC_W-1:0] vec_addr,
    input logic                       trap_err
);
    localparam int LAST_VEC = irqx_pkg::VEC_BASE + NUM_GRP * irqx_pkg::GRP_STRIDE - 2;

    AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> ((flags & $past(req)) == $past(req))); // R2

    AST_TRAP_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && trap && trap_num != '0 && int'(trap_num) <= NUM_GRP)
        |=> (vec_valid && int'(vec_addr) == irqx_pkg::VEC_BASE
             + (int'($past(trap_num)) - 1) * irqx_pkg::GRP_STRIDE)); // R6

    AST_TRAP_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && trap && trap_num == '0) |=> (trap_err && !vec_valid)); // R7

    AST_SERVICE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && cpu_ack && !trap && cpu_ack_grp != '0
         && int'(cpu_ack_grp) <= NUM_GRP && cpu_irq[cpu_ack_grp - 1'b1])
        |=> (vec_valid && ack_bits[$past(cpu_ack_grp) - 1'b1])); // R4

    AST_OFF_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (cpu_irq == '0)); // R8

    AST_OFF_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (!vec_valid && !trap_err)); // R8

    AST_GATE_BLOCKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_irq & ack_bits) == '0)); // R1

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_addr) >= irqx_pkg::VEC_BASE
                       && int'(vec_addr) <= LAST_VEC && !vec_addr[0])); // R3

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && trap_err)); // R7
endmodule

bind irq_group_expander irqx_checker #(
    .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .GNUM_W(GNUM_W)
) u_irqx_checker (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .req(req_i), .flags(ifr_all),
    .ack_bits(ack_all), .cpu_irq(cpu_irq_o), .cpu_ack(cpu_ack_i),
    .cpu_ack_grp(cpu_ack_grp_i), .trap(trap_i), .trap_num(trap_num_i),
    .vec_valid(vec_valid_o), .vec_addr(vec_addr_o), .trap_err(trap_err_o)
);

// File: tb/irq_group_expander_bench.sv
`timescale 1ns/1ps
module irq_group_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] req = '0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [11:0] irq;
    logic        ack = 1'b0;
    logic [3:0]  ack_grp = '0;
    logic        trap = 1'b0;
    logic [3:0]  trap_num = '0;
    logic        vvalid;
    logic [11:0] vaddr;
    logic        terr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [12:0] exp_q[$];

    always #2 clk = ~clk;

    irq_group_expander u_irq_group_expander (
        .clk(clk), .rst_n(rst_n), .req_i(req), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cpu_irq_o(irq),
        .cpu_ack_i(ack), .cpu_ack_grp_i(ack_grp), .trap_i(trap),
        .trap_num_i(trap_num), .vec_valid_o(vvalid), .vec_addr_o(vaddr),
        .trap_err_o(terr)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic pulse(input int bitpos);
        @(negedge clk); req[bitpos] = 1'b1;
        @(negedge clk); req = '0;
    endtask

    // Driver: trap request, pushing the expected result when one is due.
    task automatic do_trap(input logic [3:0] n, input bit expect_out, input logic [12:0] item);
        @(negedge clk);
        if (expect_out) exp_q.push_back(item);
        trap = 1'b1; trap_num = n;
        @(negedge clk); trap = 1'b0;
    endtask

    // Driver: CPU acknowledge, pushing the expected vector when one is due.
    task automatic do_ack(input logic [3:0] g, input bit expect_out, input logic [11:0] va);
        @(negedge clk);
        if (expect_out) exp_q.push_back({1'b0, va});
        ack = 1'b1; ack_grp = g;
        @(negedge clk); ack = 1'b0;
    endtask

    // Monitor: compare every produced result with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && (vvalid || terr)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected output", {19'd0, terr, vaddr}, 0);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                check({terr, vaddr} == e && (vvalid != terr), "R3/R4/R6/R7 vector",
                      {19'd0, terr, vaddr}, {19'd0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        rd(5'd0, d);  check(d == 0, "R12 ctrl", d, 0);
        rd(5'd1, d);  check(d == 0, "R12 ack reg", d, 0);
        check(irq == 0 && !vvalid && !terr, "R12 outputs", irq, 0);

        // R8 disabled: flag with enable, no line, no trap output
        wr(5'd2, 16'h0001);
        pulse(0);
        check(irq == 0, "R8 line while off", irq, 0);
        do_trap(4'd1, 1'b0, '0);
        @(negedge clk);
        check(!vvalid && !terr, "R8 trap while off", {vvalid, terr}, 0);

        // R1 enable raises the pending line
        wr(5'd0, 16'h0001);
        #1; check(irq == 12'h001, "R1 line on enable", irq, 12'h001);
        do_ack(4'd1, 1'b1, 12'hD40);
        wr(5'd1, 16'h0001);

        // R2/R3 two sources in group 4: index 3 wins, then index 5
        wr(5'd8, 16'h00FF);
        @(negedge clk); req[26] = 1'b1; req[28] = 1'b1;
        @(negedge clk); req = '0;
        rd(5'd9, d);  check(d == 16'h0014, "R2 flags latched", d, 16'h0014);
        check(irq[3], "R1 group 4 line", irq, 12'h008);
        do_ack(4'd4, 1'b1, 12'hD74);
        #1; check(!irq[3], "R4 gate closes line", irq, 0);
        rd(5'd1, d);  check(d == 16'h0008, "R4 ack bit set", d, 16'h0008);
        rd(5'd9, d);  check(d == 16'h0010, "R4 only winner cleared", d, 16'h0010);
        wr(5'd1, 16'h0008);
        #1; check(irq[3], "R5 write-1 reopens gate", irq, 12'h008);
        do_ack(4'd4, 1'b1, 12'hD78);
        wr(5'd1, 16'h0000);
        rd(5'd1, d);  check(d == 16'h0008, "R5 write-0 keeps bit", d, 16'h0008);
        wr(5'd1, 16'h0008);

        // R1 masked flag in group 2 raises nothing
        pulse(9);
        rd(5'd5, d);  check(d == 16'h0002, "R9 flag offset group 2", d, 16'h0002);
        check(irq == 0, "R1 masked source", irq, 0);

        // R6/R7 traps
        do_trap(4'd1,  1'b1, {1'b0, 12'hD40});
        do_trap(4'd12, 1'b1, {1'b0, 12'hDF0});
        do_trap(4'd0,  1'b1, {1'b1, 12'h000});
        do_trap(4'd13, 1'b1, {1'b1, 12'h000});
        rd(5'd1, d);  check(d == 0, "R6 trap leaves ack reg", d, 0);
        rd(5'd5, d);  check(d == 16'h0002, "R6 trap leaves flags", d, 16'h0002);

        // R11 software interrupt in group 7, slot 8
        wr(5'd14, 16'h0080);
        wr(5'd15, 16'h0080);
        #1; check(irq == 12'h040, "R11 software flag line", irq, 12'h040);
        do_ack(4'd7, 1'b1, 12'hDAE);
        wr(5'd1, 16'h0040);

        // R10 clear write racing a request in group 9
        pulse(64);
        @(negedge clk); we = 1'b1; addr = 5'd19; wdata = 16'h0000; req[66] = 1'b1;
        @(negedge clk); we = 1'b0; req = '0;
        rd(5'd19, d); check(d == 16'h0004, "R10 request survives clear", d, 16'h0004);

        // R9 reserved offsets read zero
        rd(5'h1A, d); check(d == 0, "R9 reserved 0x1A", d, 0);
        rd(5'h1F, d); check(d == 0, "R9 reserved 0x1F", d, 0);
        rd(5'd0, d);  check(d == 16'h0001, "R9 ctrl readback", d, 1);

        // R8 disabling drops lines and ignores acknowledges
        wr(5'd18, 16'h0004);
        #1; check(irq == 12'h100, "R1 group 9 line", irq, 12'h100);
        wr(5'd0, 16'h0000);
        #1; check(irq == 0, "R8 lines low when off", irq, 0);
        do_ack(4'd9, 1'b0, '0);
        @(negedge clk);
        check(!vvalid && !terr, "R8 ack while off", {vvalid, terr}, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all results produced", exp_q.size(), 0);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule